// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

The block is a down-counting watchdog. Its counter runs in a low-speed clock domain of its own and does not depend on the bus clock. Software reaches it through four 16-bit registers in the bus clock domain:

| Address | Register |
|---|---|
| 0 | key |
| 1 | prescaler code |
| 2 | reload value |
| 3 | status |

Special values written to the key register do three things: they open the configuration registers for writing, they load the counter from the reload value (a refresh), and they start the watchdog. Once started, software cannot stop it, and the block holds an oscillator-enable output high. When the counter is at zero and a prescaled tick arrives, the block drives a reset pulse of fixed length in the watchdog clock domain. It then reloads and keeps counting.

New prescaler and reload values cross into the watchdog domain through a toggle handshake. A busy flag in the status register stays set until the watchdog domain has acknowledged the value. A sticky cause flag in the bus domain records that a watchdog reset pulse happened. The system reset does not clear it; only a power-on reset or an explicit clear strobe does. The system integrator feeds the reset pulse back into the system reset.

Top module: `keyed_wdog`

## Requirements
- R1: Out of reset the prescaler register (address 1) reads 0 and the reload register (address 2) reads 0xFFF. The status register (address 3) reads 0. The reset pulse, the cause flag and the oscillator-enable output are all low. The internal count starts at 0xFFF.
- R2: Key 0x5555 (written to address 0) opens writes to the prescaler and reload registers. Key 0x0000 closes them again. While the registers are closed, writes to them leave the read-back value unchanged.
- R3: Key 0xAAAA loads the counter from the reload value and restarts the prescaler phase. Key 0xCCCC starts the watchdog. Either key also closes the configuration registers.
- R4: A key write of any value other than 0x5555, 0x0000, 0xAAAA or 0xCCCC changes nothing: an open configuration stays open.
- R5: Prescaler code c (3 bits) divides the watchdog clock by 4·2^c for c = 0..6. Code 7 divides by 256, the same as code 6.
- R6: While running, the time between the starts of two successive reset pulses is exactly 4·2^c·(reload+1) watchdog-clock cycles. When the count reaches zero, the counter reloads and keeps running.
- R7: Started with no refresh and the default configuration, the first reset pulse begins 16384 watchdog-clock cycles after the start. The count of 16384 excludes a synchronizer latency of a few cycles.
- R8: Status bit 0 (prescaler) and bit 1 (reload) rise on the bus cycle after an accepted write to that register. Each clears only after the watchdog domain acknowledges the value. A write to a register whose busy flag is set is ignored.
- R9: No reset pulse occurs before the start key. After the start key, no key value stops the counter, and the oscillator-enable output stays high until system reset.
- R10: Each reset pulse lasts exactly 4 watchdog-clock cycles (parameter RST_CYCLES).
- R11: The cause flag rises after a reset pulse and survives the system reset. The clear strobe clears it, and so does the power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock |
| wdClk | input | 1 | Independent low-speed watchdog clock |
| rstN | input | 1 | System reset, active low, asynchronous |
| porRstN | input | 1 | Power-on reset for the cause flag, active low |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address: 0 key, 1 prescaler, 2 reload, 3 status |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, combinational |
| causeClr | input | 1 | Clears the sticky cause flag |
| causeFlag | output | 1 | Sticky watchdog-reset cause flag |
| oscForceOn | output | 1 | Keeps the watchdog oscillator enabled once started |
| wdRstOut | output | 1 | Reset pulse, watchdog clock domain |

## Verification
The assertions check on every cycle the following:
- The running state, once entered, never clears without a system reset.
- A configuration value never changes while its handshake is outstanding.
- No reset pulse appears without the start having crossed into the watchdog domain, and every pulse is longer than one cycle.
- The cause flag holds until it is cleared.

Only the bench scenarios can show the rest:
- the exact pulse-to-pulse period for each prescaler code;
- the 16384-cycle first timeout from the default count;
- the key decoding and locking seen through read-back;
- that the cause flag survives a system reset.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_OPEN    = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_CLOSE   = 16'h0000;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

  localparam logic [1:0] ADDR_KEY  = 2'd0;
  localparam logic [1:0] ADDR_PRE  = 2'd1;
  localparam logic [1:0] ADDR_RLD  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  // Strobes from the bus-side control to the watchdog-side datapath
  typedef struct packed {
    logic preReq;      // toggles when a new prescaler value is posted
    logic rldReq;      // toggles when a new reload value is posted
    logic refreshTgl;  // toggles on each refresh key
    logic runLvl;      // level, high once started
  } xStrobe_t;
endpackage

// File: rtl/kwdt_sync.sv
module kwdt_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] shiftQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shiftQ <= '0;
      else       shiftQ <= {shiftQ[STAGES-2:0], d[b]};
    end
    assign q[b] = shiftQ[STAGES-1];
  end
endmodule

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PRE_W = 3
) (
  input  logic             busClk,
  input  logic             rstN,
  input  logic             porRstN,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [KEY_W-1:0] busWdata,
  output logic [KEY_W-1:0] busRdata,
  input  logic             causeClr,
  output logic             causeFlag,
  output logic             oscForceOn,
  output xStrobe_t         strobe,
  input  logic             preAckS,
  input  logic             rldAckS,
  input  logic             wdRstS,
  output logic [PRE_W-1:0] preVal,
  output logic [CNT_W-1:0] rldVal
);
  logic unlockedQ, startedQ, preReqQ, rldReqQ, refreshQ;
  logic preBusy, rldBusy;
  logic wrKey, wrPre, wrRld;
  logic wdRstD;

  assign preBusy = preReqQ != preAckS;
  assign rldBusy = rldReqQ != rldAckS;
  assign wrKey = busWr && (busAddr == ADDR_KEY);
  assign wrPre = busWr && (busAddr == ADDR_PRE) && unlockedQ && !preBusy;
  assign wrRld = busWr && (busAddr == ADDR_RLD) && unlockedQ && !rldBusy;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      unlockedQ <= 1'b0;
      startedQ  <= 1'b0;
      refreshQ  <= 1'b0;
      preReqQ   <= 1'b0;
      rldReqQ   <= 1'b0;
      preVal    <= '0;
      rldVal    <= '1;
    end else begin
      if (wrKey) begin
        case (busWdata)
          KEY_OPEN:    unlockedQ <= 1'b1;
          KEY_CLOSE:   unlockedQ <= 1'b0;
          KEY_REFRESH: begin
            unlockedQ <= 1'b0;
            refreshQ  <= ~refreshQ;
          end
          KEY_START: begin
            unlockedQ <= 1'b0;
            startedQ  <= 1'b1;
          end
          default: ;
        endcase
      end
      if (wrPre) begin
        preVal  <= busWdata[PRE_W-1:0];
        preReqQ <= ~preReqQ;
      end
      if (wrRld) begin
        rldVal  <= busWdata[CNT_W-1:0];
        rldReqQ <= ~rldReqQ;
      end
    end
  end

  // Sticky cause flag lives on the power-on reset only
  always_ff @(posedge busClk or negedge porRstN) begin
    if (!porRstN) begin
      wdRstD    <= 1'b0;
      causeFlag <= 1'b0;
    end else begin
      wdRstD <= wdRstS;
      if (wdRstS && !wdRstD)  causeFlag <= 1'b1;
      else if (causeClr)      causeFlag <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_PRE:  busRdata[PRE_W-1:0] = preVal;
      ADDR_RLD:  busRdata[CNT_W-1:0] = rldVal;
      ADDR_STAT: busRdata[1:0]       = {rldBusy, preBusy};
      default:   busRdata = '0;
    endcase
  end

  assign strobe = '{preReq: preReqQ, rldReq: rldReqQ,
                    refreshTgl: refreshQ, runLvl: startedQ};
  assign oscForceOn = startedQ;
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
  import kwdt_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int PRE_W      = 3,
  parameter int RST_CYCLES = 4
) (
  input  logic             wdClk,
  input  logic             rstN,
  input  xStrobe_t         strobeS,
  input  logic [PRE_W-1:0] preVal,
  input  logic [CNT_W-1:0] rldVal,
  output logic             preAck,
  output logic             rldAck,
  output logic             rstOut
);
  localparam int MAX_CODE = (1 << PRE_W) - 2;
  localparam int DIV_W    = MAX_CODE + 2;
  localparam int PC_W     = $clog2(RST_CYCLES + 1);

  logic [PRE_W-1:0] preWd, codeEff;
  logic [CNT_W-1:0] rldWd, cnt;
  logic [DIV_W-1:0] divCnt, divLimit;
  logic [DIV_W:0]   divisor;
  logic [PC_W-1:0]  pulseCnt;
  logic refreshSeen, refreshEv, tick, fire;

  assign codeEff  = (int'(preWd) > MAX_CODE) ? PRE_W'(MAX_CODE) : preWd;
  assign divisor  = (DIV_W+1)'(4) << codeEff;
  assign divLimit = DIV_W'(divisor - 1'b1);

  assign refreshEv = strobeS.refreshTgl != refreshSeen;
  assign tick      = strobeS.runLvl && (divCnt == divLimit);
  assign fire      = tick && (cnt == '0) && !refreshEv;

  // Handshake receivers: capture then acknowledge
  always_ff @(posedge wdClk or negedge rstN) begin
    if (!rstN) begin
      preAck      <= 1'b0;
      rldAck      <= 1'b0;
      preWd       <= '0;
      rldWd       <= '1;
      refreshSeen <= 1'b0;
    end else begin
      preAck      <= strobeS.preReq;
      rldAck      <= strobeS.rldReq;
      refreshSeen <= strobeS.refreshTgl;
      if (strobeS.preReq != preAck) preWd <= preVal;
      if (strobeS.rldReq != rldAck) rldWd <= rldVal;
    end
  end

  // Prescaler and down counter
  always_ff @(posedge wdClk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      cnt    <= '1;
    end else if (refreshEv) begin
      divCnt <= '0;
      cnt    <= rldWd;
    end else if (strobeS.runLvl) begin
      if (tick) begin
        divCnt <= '0;
        cnt    <= (cnt == '0) ? rldWd : cnt - 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // Fixed-length reset pulse
  always_ff @(posedge wdClk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
      rstOut   <= 1'b0;
    end else if (fire) begin
      pulseCnt <= PC_W'(RST_CYCLES - 1);
      rstOut   <= 1'b1;
    end else begin
      rstOut <= pulseCnt != '0;
      if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwdt_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int PRE_W       = 3,
  parameter int RST_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        busClk,
  input  logic        wdClk,
  input  logic        rstN,
  input  logic        porRstN,
  input  logic        busWr,
  input  logic [1:0]  busAddr,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  input  logic        causeClr,
  output logic        causeFlag,
  output logic        oscForceOn,
  output logic        wdRstOut
);
  localparam int SW = $bits(xStrobe_t);

  xStrobe_t         strobeB, strobeW;
  logic [SW-1:0]    strobeWBits;
  logic             preAckW, rldAckW, preAckB, rldAckB, wdRstB;
  logic [PRE_W-1:0] preVal;
  logic [CNT_W-1:0] rldVal;

  kwdt_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W)) ctrl_i (
    .busClk(busClk), .rstN(rstN), .porRstN(porRstN),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .causeClr(causeClr), .causeFlag(causeFlag), .oscForceOn(oscForceOn),
    .strobe(strobeB), .preAckS(preAckB), .rldAckS(rldAckB), .wdRstS(wdRstB),
    .preVal(preVal), .rldVal(rldVal)
  );

  kwdt_sync #(.STAGES(SYNC_STAGES), .WIDTH(SW)) toWd_i (
    .clk(wdClk), .rstN(rstN), .d(strobeB), .q(strobeWBits)
  );
  assign strobeW = xStrobe_t'(strobeWBits);

  kwdt_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) ackToBus_i (
    .clk(busClk), .rstN(rstN), .d({rldAckW, preAckW}), .q({rldAckB, preAckB})
  );

  kwdt_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) rstToBus_i (
    .clk(busClk), .rstN(porRstN), .d(wdRstOut), .q(wdRstB)
  );

  kwdt_core #(.CNT_W(CNT_W), .PRE_W(PRE_W), .RST_CYCLES(RST_CYCLES)) core_i (
    .wdClk(wdClk), .rstN(rstN), .strobeS(strobeW),
    .preVal(preVal), .rldVal(rldVal),
    .preAck(preAckW), .rldAck(rldAckW), .rstOut(wdRstOut)
  );
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
  import kwdt_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PRE_W = 3
) (
  input logic             busClk,
  input logic             wdClk,
  input logic             rstN,
  input logic             porRstN,
  input logic             causeClr,
  input logic             causeFlag,
  input logic             oscForceOn,
  input logic             wdRstOut,
  input xStrobe_t         strobeB,
  input xStrobe_t         strobeW,
  input logic             preAckB,
  input logic             rldAckB,
  input logic [PRE_W-1:0] preVal,
  input logic [CNT_W-1:0] rldVal
);
  // R9: the start cannot be undone by software
  assert_start_sticky_R9: assert property (@(posedge busClk) disable iff (!rstN)
    oscForceOn |=> oscForceOn);

  // R8: a posted value holds until acknowledged
  assert_pre_hold_R8: assert property (@(posedge busClk) disable iff (!rstN)
    (strobeB.preReq != preAckB) |=> $stable(preVal));
  assert_rld_hold_R8: assert property (@(posedge busClk) disable iff (!rstN)
    (strobeB.rldReq != rldAckB) |=> $stable(rldVal));

  // R9: no reset pulse unless the start has reached the watchdog domain
  assert_no_early_reset_R9: assert property (@(posedge wdClk) disable iff (!rstN)
    wdRstOut |-> strobeW.runLvl);

  // R10: a pulse is never a single cycle
  assert_pulse_width_R10: assert property (@(posedge wdClk) disable iff (!rstN)
    $rose(wdRstOut) |=> wdRstOut);

  // R11: cause flag holds until cleared
  assert_cause_sticky_R11: assert property (@(posedge busClk) disable iff (!porRstN)
    (causeFlag && !causeClr) |=> causeFlag);
endmodule

bind keyed_wdog kwdt_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) chk_i (
  .busClk(busClk), .wdClk(wdClk), .rstN(rstN), .porRstN(porRstN),
  .causeClr(causeClr), .causeFlag(causeFlag), .oscForceOn(oscForceOn),
  .wdRstOut(wdRstOut), .strobeB(strobeB), .strobeW(strobeW),
  .preAckB(preAckB), .rldAckB(rldAckB), .preVal(preVal), .rldVal(rldVal)
);

// File: tb/keyed_wdog_tb_top.sv
module keyed_wdog_tb_top;
  localparam int NVEC = 7;
  localparam int VEC_CODE [NVEC] = '{0, 1, 2, 0, 3, 6, 7};
  localparam int VEC_RLD  [NVEC] = '{1, 3, 2, 5, 1, 0, 0};
  localparam int VEC_EXP  [NVEC] = '{8, 32, 48, 24, 64, 256, 256};

  logic busClk = 0, wdClk = 0;
  logic rstN = 0, porRstN = 0;
  logic busWr = 0, causeClr = 0;
  logic [1:0] busAddr = 0;
  logic [15:0] busWdata = 0;
  logic [15:0] busRdata;
  logic causeFlag, oscForceOn, wdRstOut;

  int nTests = 0, nFail = 0;
  bit done = 0;

  always #2 busClk = ~busClk;   // 250 MHz
  always #6 wdClk  = ~wdClk;

  keyed_wdog dut_i (
    .busClk(busClk), .wdClk(wdClk), .rstN(rstN), .porRstN(porRstN),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .causeClr(causeClr), .causeFlag(causeFlag), .oscForceOn(oscForceOn),
    .wdRstOut(wdRstOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    nTests++;
    if (act < lo || act > hi) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge busClk);
    busWr = 1; busAddr = a; busWdata = d;
    @(negedge busClk);
    busWr = 0;
  endtask

  task automatic busRead(input logic [1:0] a, output int v);
    @(negedge busClk);
    busAddr = a;
    #1 v = int'(busRdata);
  endtask

  task automatic waitIdle();
    int s;
    for (int i = 0; i < 200; i++) begin
      busRead(2'd3, s);
      if (s == 0) break;
    end
  endtask

  // counts watchdog-clock cycles until the next rising pulse
  task automatic waitRise(input int limit, output int n);
    n = 0;
    while (wdRstOut === 1'b1 && n < limit) begin @(negedge wdClk); n++; end
    while (wdRstOut !== 1'b1 && n < limit) begin @(negedge wdClk); n++; end
  endtask

  task automatic doReset(input bit por);
    @(negedge busClk);
    rstN = 0;
    if (por) porRstN = 0;
    repeat (4) @(negedge wdClk);
    @(negedge busClk);
    rstN = 1; porRstN = 1;
    repeat (4) @(negedge wdClk);
  endtask

  initial begin
    repeat (200000) @(posedge busClk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int v, n;
    doReset(1);

    // R1 reset state
    busRead(2'd1, v); check("R1 prescaler reset", v, 0);
    busRead(2'd2, v); check("R1 reload reset", v, 'hFFF);
    busRead(2'd3, v); check("R1 status reset", v, 0);
    check("R1 pulse low", int'(wdRstOut), 0);
    check("R1 cause low", int'(causeFlag), 0);
    check("R1 osc enable low", int'(oscForceOn), 0);

    // R7 first timeout from the default count
    busWrite(2'd0, 16'hCCCC);
    check("R9 osc forced on", int'(oscForceOn), 1);
    waitRise(20000, n);
    checkRange("R7 first timeout", n, 16383, 16392);

    // R10 pulse width
    n = 0;
    while (wdRstOut === 1'b1 && n < 50) begin @(negedge wdClk); n++; end
    check("R10 pulse width", n, 4);

    // R11 flag set, survives system reset, cleared by strobe
    repeat (6) @(negedge busClk);
    check("R11 cause set", int'(causeFlag), 1);
    doReset(0);
    check("R11 cause survives rstN", int'(causeFlag), 1);
    check("R9 osc released by rstN", int'(oscForceOn), 0);
    @(negedge busClk); causeClr = 1;
    @(negedge busClk); causeClr = 0;
    #1 check("R11 cause cleared", int'(causeFlag), 0);

    // R9 no pulse before start
    busWrite(2'd0, 16'h5555);
    busWrite(2'd1, 16'd0);
    busWrite(2'd2, 16'd1);
    waitIdle();
    busWrite(2'd0, 16'hAAAA);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge wdClk);
      if (wdRstOut === 1'b1) n++;
    end
    check("R9 no pulse before start", n, 0);

    // R3 refresh closed the registers
    busWrite(2'd1, 16'd3);
    busRead(2'd1, v); check("R3 refresh relocks", v, 0);
    // R2 close key
    busWrite(2'd0, 16'h5555);
    busWrite(2'd0, 16'h0000);
    busWrite(2'd1, 16'd3);
    busRead(2'd1, v); check("R2 locked write ignored", v, 0);
    // R4 unknown key keeps it open
    busWrite(2'd0, 16'h5555);
    busWrite(2'd0, 16'h1234);
    busWrite(2'd1, 16'd3);
    busRead(2'd1, v); check("R4 unknown key ignored", v, 3);
    waitIdle();

    // R8 busy flags and writes while busy
    busWrite(2'd0, 16'h5555);
    busWrite(2'd1, 16'd2);
    busRead(2'd3, v); check("R8 prescaler busy set", v & 1, 1);
    busWrite(2'd1, 16'd5);
    busRead(2'd1, v); check("R8 write while busy ignored", v, 2);
    busWrite(2'd2, 16'd7);
    busRead(2'd3, v); check("R8 reload busy set", (v >> 1) & 1, 1);
    waitIdle();
    busRead(2'd3, v); check("R8 busy flags cleared", v, 0);
    busRead(2'd2, v); check("R2 reload written", v, 7);

    // R3 start key also closes the registers
    busWrite(2'd0, 16'h5555);
    busWrite(2'd0, 16'hCCCC);
    busWrite(2'd1, 16'd6);
    busRead(2'd1, v); check("R3 start relocks", v, 2);

    // R5 / R6 period table
    for (int k = 0; k < NVEC; k++) begin
      busWrite(2'd0, 16'h5555);
      busWrite(2'd1, 16'(VEC_CODE[k]));
      busWrite(2'd2, 16'(VEC_RLD[k]));
      waitIdle();
      busWrite(2'd0, 16'hAAAA);
      waitRise(5000, n);
      waitRise(5000, n);
      check($sformatf("R6 R5 period code %0d reload %0d", VEC_CODE[k], VEC_RLD[k]),
            n, VEC_EXP[k]);
    end

    // R9 no key stops it
    busWrite(2'd0, 16'h0000);
    busWrite(2'd0, 16'h5A5A);
    waitRise(5000, n);
    waitRise(5000, n);
    check("R9 still running after keys", n, 256);
    check("R9 osc still forced", int'(oscForceOn), 1);

    // R11 power-on reset clears the flag
    check("R11 cause set again", int'(causeFlag), 1);
    doReset(1);
    check("R11 cleared by power-on reset", int'(causeFlag), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule